// File: doc/BRIEF.md
# Data Cache Miss Merge Buffer

This block keeps track of first-level data cache misses that are waiting for a block fill from the next cache level. Two pipelines can present a load or store miss in the same cycle. Each miss carries a byte address, a store flag and a reference tag. Misses that fall in the same 64-byte block share one tracking entry. Each entry issues a single fill request to the next level, so the next level never sees two requests for the same block.

Fill requests leave through a ready/valid output, oldest allocation first. When the next level returns a fill for an entry, the block reports every reference tag merged into that entry on a completion output, one tag per cycle, and frees the entry on the last beat. If the fill displaces a modified line, the block pushes that line's block address into an external victim queue. When that queue signals full, the fill return is held off until there is room.

Top module: `miss_merge_buf`

## Requirements
- R1: After a synchronous active-high reset, no fill request is valid, no completion or victim push is signalled, both miss ports accept a new miss, and a fill return is accepted.
- R2: A miss to a block with no open entry takes the lowest-numbered free entry and produces exactly one fill request. The request carries the block address (byte address bits above bit 5) and the entry number.
- R3: A miss whose byte address differs from an open entry's block only in bits 5:0 joins that entry, is accepted, and creates no new fill request.
- R4: If both ports miss to the same new block in the same cycle, one entry is allocated and one fill request is produced. Both references are attached to that entry.
- R5: When all 16 entries are in use, a miss to a new block is refused (its accept output is low). A miss that merges into an open entry is still accepted.
- R6: An entry holds at most 8 references. A further miss to that block is refused, including the second port's miss in the same cycle.
- R7: Fill requests are issued one per cycle in allocation order, with port 0's allocation ahead of port 1's. A request is held with the same entry and address while ready is low.
- R8: After a fill return is accepted, the entry's tags appear on the completion output one per cycle, starting two cycles after the return. Each tag carries its store flag, in arrival order, with port 0 ahead of port 1 within a cycle. The entry is free from the cycle after its last beat, so a later miss to that block allocates it again.
- R9: A fill return marked dirty is accepted only while the victim queue is not full. One cycle after it is accepted, the victim push output pulses with the returned victim block address. A clean fill return is accepted regardless of the victim queue's full flag.
- R10: While the tags of an earlier fill are still being reported, a new fill return is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| p0_vld | input | 1 | Port 0 miss present |
| p0_addr | input | ADDR_W | Port 0 byte address |
| p0_st | input | 1 | Port 0 store flag (1 = store) |
| p0_tag | input | TAG_W | Port 0 reference tag |
| p0_take | output | 1 | Port 0 miss accepted this cycle |
| p1_vld | input | 1 | Port 1 miss present |
| p1_addr | input | ADDR_W | Port 1 byte address |
| p1_st | input | 1 | Port 1 store flag (1 = store) |
| p1_tag | input | TAG_W | Port 1 reference tag |
| p1_take | output | 1 | Port 1 miss accepted this cycle |
| fill_req_vld | output | 1 | Fill request valid |
| fill_req_rdy | input | 1 | Next level takes the fill request |
| fill_req_blk | output | ADDR_W-6 | Block address of the request |
| fill_req_id | output | ID_W | Entry number of the request |
| fill_rtn_vld | input | 1 | Fill return present |
| fill_rtn_id | input | ID_W | Entry number the fill belongs to |
| fill_rtn_dirty | input | 1 | Fill displaces a modified line |
| fill_rtn_vic_blk | input | ADDR_W-6 | Block address of the displaced line |
| fill_rtn_rdy | output | 1 | Fill return accepted this cycle |
| cmp_vld | output | 1 | Completion beat valid |
| cmp_tag | output | TAG_W | Completed reference tag |
| cmp_st | output | 1 | Store flag of the completed reference |
| vic_full | input | 1 | Victim queue has no room |
| vic_push | output | 1 | Push a victim into the queue |
| vic_blk | output | ADDR_W-6 | Block address of the pushed victim |

## Verification
The merge logic is tried with four input patterns. A lone miss to a new block separates allocation from merging. A second miss differing only in the low six address bits shows that those bits are ignored. Both ports hitting one new block in the same cycle must yield one request, not two. One port merging while the other allocates checks that the two ports are handled independently. Eight same-block references, followed by a ninth on both ports, expose the per-entry tag limit. Sixteen distinct blocks, followed by one new block and one merging miss, separate the entry limit from the merge path. Dirty and clean fill returns against a full victim queue, and a return offered during an ongoing drain, show which condition holds off a fill.

// File: rtl/mmb_pkg.sv
package mmb_pkg;

  // Lifecycle of one tracking entry
  typedef enum logic [1:0] {
    ST_FREE  = 2'd0,  // unused
    ST_WAIT  = 2'd1,  // allocated, fill request not yet taken
    ST_PEND  = 2'd2,  // fill request taken, waiting for data
    ST_DRAIN = 2'd3   // data returned, tags being reported
  } ent_st_e;

endpackage

// File: rtl/mmb_alloc.sv
module mmb_alloc #(
  parameter int NUM_ENT  = 16,
  parameter int TAGS_PER = 8,
  parameter int BLK_W    = 26,
  localparam int ID_W    = $clog2(NUM_ENT),
  localparam int CNT_W   = $clog2(TAGS_PER + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               p0_vld,
  input  logic [BLK_W-1:0]   p0_blk,
  input  logic               p1_vld,
  input  logic [BLK_W-1:0]   p1_blk,
  input  logic [NUM_ENT-1:0] open_mask,
  input  logic [NUM_ENT-1:0] free_mask,
  input  logic [BLK_W-1:0]   ent_blk [NUM_ENT],
  input  logic [CNT_W-1:0]   ent_cnt [NUM_ENT],
  output logic               p0_take,
  output logic               p1_take,
  output logic               w0_vld,
  output logic [ID_W-1:0]    w0_ent,
  output logic [CNT_W-1:0]   w0_slot,
  output logic               w1_vld,
  output logic [ID_W-1:0]    w1_ent,
  output logic [CNT_W-1:0]   w1_slot,
  output logic               new0_vld,
  output logic               new1_vld,
  output logic [ID_W-1:0]    new1_ent
);

  localparam logic [CNT_W-1:0] CAP = CNT_W'(TAGS_PER);

  logic [NUM_ENT-1:0] match0, match1;
  logic               hit0, hit1, same_blk;
  logic [ID_W-1:0]    h0, h1;
  logic               any_a, any_b;
  logic [ID_W-1:0]    f_a, f_b;

  // Per-entry block compare for both ports
  generate
    for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
      assign match0[g] = open_mask[g] && (ent_blk[g] == p0_blk);
      assign match1[g] = open_mask[g] && (ent_blk[g] == p1_blk);
    end
  endgenerate

  assign hit0     = |match0;
  assign hit1     = |match1;
  assign same_blk = p0_vld && p1_vld && (p0_blk == p1_blk);

  // Encoders: owning entry per port, first and second free entry
  always_comb begin
    h0    = '0;
    h1    = '0;
    any_a = 1'b0;
    f_a   = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (match0[i]) h0 = ID_W'(i);
      if (match1[i]) h1 = ID_W'(i);
      if (free_mask[i]) begin
        any_a = 1'b1;
        f_a   = ID_W'(i);
      end
    end
    any_b = 1'b0;
    f_b   = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (free_mask[i] && (ID_W'(i) != f_a)) begin
        any_b = 1'b1;
        f_b   = ID_W'(i);
      end
    end
  end

  always_comb begin
    p0_take  = 1'b0;
    p1_take  = 1'b0;
    w0_vld   = 1'b0;
    w0_ent   = '0;
    w0_slot  = '0;
    w1_vld   = 1'b0;
    w1_ent   = '0;
    w1_slot  = '0;
    new0_vld = 1'b0;
    new1_vld = 1'b0;
    new1_ent = '0;

    // Port 0 has priority
    if (p0_vld) begin
      if (hit0) begin
        if (ent_cnt[h0] < CAP) begin
          p0_take = 1'b1;
          w0_vld  = 1'b1;
          w0_ent  = h0;
          w0_slot = ent_cnt[h0];
        end
      end else if (any_a) begin
        p0_take  = 1'b1;
        new0_vld = 1'b1;
        w0_vld   = 1'b1;
        w0_ent   = f_a;
        w0_slot  = '0;
      end
    end

    if (p1_vld) begin
      if (same_blk) begin
        // Attach behind port 0 in the same entry, if port 0 got in
        if (p0_take && ((w0_slot + CNT_W'(1)) < CAP)) begin
          p1_take = 1'b1;
          w1_vld  = 1'b1;
          w1_ent  = w0_ent;
          w1_slot = w0_slot + CNT_W'(1);
        end
      end else if (hit1) begin
        if (ent_cnt[h1] < CAP) begin
          p1_take = 1'b1;
          w1_vld  = 1'b1;
          w1_ent  = h1;
          w1_slot = ent_cnt[h1];
        end
      end else if (new0_vld ? any_b : any_a) begin
        p1_take  = 1'b1;
        new1_vld = 1'b1;
        new1_ent = new0_vld ? f_b : f_a;
        w1_vld   = 1'b1;
        w1_ent   = new1_ent;
        w1_slot  = '0;
      end
    end
  end

  // R3: a block is owned by at most one open entry
  a_r3_one_owner: assert property (@(posedge clk) disable iff (rst)
    p0_vld |-> $onehot0(match0));

  // R4: two allocations in one cycle never pick the same entry
  a_r4_distinct_alloc: assert property (@(posedge clk) disable iff (rst)
    (new0_vld && new1_vld) |-> (w0_ent != w1_ent));

endmodule

// File: rtl/mmb_order_q.sv
module mmb_order_q #(
  parameter int DEPTH   = 16,   // power of two
  parameter int ID_W    = 4,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push_a,
  input  logic [ID_W-1:0] id_a,
  input  logic            push_b,
  input  logic [ID_W-1:0] id_b,
  input  logic            pop,
  output logic [ID_W-1:0] head,
  output logic            nonempty
);

  logic [ID_W-1:0]  mem [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_pop;
  logic [PTR_W-1:0] wp_b;

  assign nonempty = (cnt_q != '0);
  assign head     = mem[rp_q];
  assign do_pop   = pop && nonempty;
  assign wp_b     = push_a ? (wp_q + PTR_W'(1)) : wp_q;

  // Storage: plain write ports, no reset
  always_ff @(posedge clk) begin
    if (push_a) mem[wp_q] <= id_a;
    if (push_b) mem[wp_b] <= id_b;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_q + PTR_W'(push_a) + PTR_W'(push_b);
      if (do_pop) rp_q <= rp_q + PTR_W'(1);
      cnt_q <= cnt_q + CNT_W'(push_a) + CNT_W'(push_b) - CNT_W'(do_pop);
    end
  end

  // R7: the order queue never holds more ids than entries exist
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(DEPTH));

endmodule

// File: rtl/miss_merge_buf.sv
module miss_merge_buf #(
  parameter int NUM_ENT  = 16,
  parameter int TAGS_PER = 8,
  parameter int ADDR_W   = 32,
  parameter int TAG_W    = 8,
  parameter int OFF_W    = 6,
  localparam int BLK_W   = ADDR_W - OFF_W,
  localparam int ID_W    = $clog2(NUM_ENT),
  localparam int CNT_W   = $clog2(TAGS_PER + 1),
  localparam int SLOTS   = NUM_ENT * TAGS_PER,
  localparam int TIDX_W  = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              p0_vld,
  input  logic [ADDR_W-1:0] p0_addr,
  input  logic              p0_st,
  input  logic [TAG_W-1:0]  p0_tag,
  output logic              p0_take,
  input  logic              p1_vld,
  input  logic [ADDR_W-1:0] p1_addr,
  input  logic              p1_st,
  input  logic [TAG_W-1:0]  p1_tag,
  output logic              p1_take,
  output logic              fill_req_vld,
  input  logic              fill_req_rdy,
  output logic [BLK_W-1:0]  fill_req_blk,
  output logic [ID_W-1:0]   fill_req_id,
  input  logic              fill_rtn_vld,
  input  logic [ID_W-1:0]   fill_rtn_id,
  input  logic              fill_rtn_dirty,
  input  logic [BLK_W-1:0]  fill_rtn_vic_blk,
  output logic              fill_rtn_rdy,
  output logic              cmp_vld,
  output logic [TAG_W-1:0]  cmp_tag,
  output logic              cmp_st,
  input  logic              vic_full,
  output logic              vic_push,
  output logic [BLK_W-1:0]  vic_blk
);

  import mmb_pkg::*;

  ent_st_e            st_q   [NUM_ENT];
  logic [BLK_W-1:0]   blk_q  [NUM_ENT];
  logic [CNT_W-1:0]   cnt_q  [NUM_ENT];
  logic [TAG_W:0]     tags_q [SLOTS];     // {store, tag}
  logic [NUM_ENT-1:0] open_mask, free_mask;

  logic [BLK_W-1:0] p0_blk, p1_blk;
  logic             w0_vld, w1_vld, new0_vld, new1_vld;
  logic [ID_W-1:0]  w0_ent, w1_ent, new1_ent;
  logic [CNT_W-1:0] w0_slot, w1_slot;
  logic [TIDX_W-1:0] w0_idx, w1_idx, rd_idx;

  logic             q_head_vld;
  logic [ID_W-1:0]  q_head;
  logic             req_fire, rtn_fire;

  logic             drn_act;
  logic [ID_W-1:0]  drn_ent;
  logic [CNT_W-1:0] drn_idx;
  logic             drn_last;

  logic             cmp_vld_q, cmp_st_q, vic_push_q;
  logic [TAG_W-1:0] cmp_tag_q;
  logic [BLK_W-1:0] vic_blk_q;

  assign p0_blk = p0_addr[ADDR_W-1:OFF_W];
  assign p1_blk = p1_addr[ADDR_W-1:OFF_W];

  generate
    for (genvar g = 0; g < NUM_ENT; g++) begin : g_mask
      assign open_mask[g] = (st_q[g] == ST_WAIT) || (st_q[g] == ST_PEND);
      assign free_mask[g] = (st_q[g] == ST_FREE);
    end
  endgenerate

  mmb_alloc #(
    .NUM_ENT  (NUM_ENT),
    .TAGS_PER (TAGS_PER),
    .BLK_W    (BLK_W)
  ) alloc_i (
    .clk       (clk),
    .rst       (rst),
    .p0_vld    (p0_vld),
    .p0_blk    (p0_blk),
    .p1_vld    (p1_vld),
    .p1_blk    (p1_blk),
    .open_mask (open_mask),
    .free_mask (free_mask),
    .ent_blk   (blk_q),
    .ent_cnt   (cnt_q),
    .p0_take   (p0_take),
    .p1_take   (p1_take),
    .w0_vld    (w0_vld),
    .w0_ent    (w0_ent),
    .w0_slot   (w0_slot),
    .w1_vld    (w1_vld),
    .w1_ent    (w1_ent),
    .w1_slot   (w1_slot),
    .new0_vld  (new0_vld),
    .new1_vld  (new1_vld),
    .new1_ent  (new1_ent)
  );

  // Allocation order for fill requests
  mmb_order_q #(
    .DEPTH (NUM_ENT),
    .ID_W  (ID_W)
  ) order_i (
    .clk      (clk),
    .rst      (rst),
    .push_a   (new0_vld),
    .id_a     (w0_ent),
    .push_b   (new1_vld),
    .id_b     (new1_ent),
    .pop      (req_fire),
    .head     (q_head),
    .nonempty (q_head_vld)
  );

  assign fill_req_vld = q_head_vld;
  assign fill_req_id  = q_head;
  assign fill_req_blk = blk_q[q_head];
  assign req_fire     = q_head_vld && fill_req_rdy;

  assign fill_rtn_rdy = !drn_act && !(fill_rtn_dirty && vic_full);
  assign rtn_fire     = fill_rtn_vld && fill_rtn_rdy;
  assign drn_last     = drn_act && (drn_idx == (cnt_q[drn_ent] - CNT_W'(1)));

  // Flat tag slot indices
  assign w0_idx = TIDX_W'(int'(w0_ent) * TAGS_PER + int'(w0_slot));
  assign w1_idx = TIDX_W'(int'(w1_ent) * TAGS_PER + int'(w1_slot));
  assign rd_idx = TIDX_W'(int'(drn_ent) * TAGS_PER + int'(drn_idx));

  // Tag storage: two write ports, one read port, no reset
  always_ff @(posedge clk) begin
    if (w0_vld) tags_q[w0_idx] <= {p0_st, p0_tag};
    if (w1_vld) tags_q[w1_idx] <= {p1_st, p1_tag};
  end

  // Block addresses of new entries
  always_ff @(posedge clk) begin
    if (new0_vld) blk_q[w0_ent]   <= p0_blk;
    if (new1_vld) blk_q[new1_ent] <= p1_blk;
  end

  // Entry lifecycle and reference counts
  generate
    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
      logic inc0, inc1, mk_new, mk_pend, mk_drain, mk_free;
      assign inc0     = w0_vld && (w0_ent == ID_W'(g));
      assign inc1     = w1_vld && (w1_ent == ID_W'(g));
      assign mk_new   = (new0_vld && (w0_ent == ID_W'(g))) ||
                        (new1_vld && (new1_ent == ID_W'(g)));
      assign mk_pend  = req_fire && (q_head == ID_W'(g));
      assign mk_drain = rtn_fire && (fill_rtn_id == ID_W'(g));
      assign mk_free  = drn_last && (drn_ent == ID_W'(g));

      always_ff @(posedge clk) begin
        if (rst) begin
          st_q[g]  <= ST_FREE;
          cnt_q[g] <= '0;
        end else begin
          if (mk_new)   st_q[g] <= ST_WAIT;
          if (mk_pend)  st_q[g] <= ST_PEND;
          if (mk_drain) st_q[g] <= ST_DRAIN;
          if (mk_free) begin
            st_q[g]  <= ST_FREE;
            cnt_q[g] <= '0;
          end else begin
            cnt_q[g] <= cnt_q[g] + CNT_W'(inc0) + CNT_W'(inc1);
          end
        end
      end

      // R6: no entry ever holds more references than its capacity
      a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q[g] <= CNT_W'(TAGS_PER));

      // R8: a draining entry takes no new references
      a_r8_no_join_drain: assert property (@(posedge clk) disable iff (rst)
        (st_q[g] == ST_DRAIN) |-> !(inc0 || inc1));
    end
  endgenerate

  // Drain engine and registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      drn_act    <= 1'b0;
      drn_ent    <= '0;
      drn_idx    <= '0;
      cmp_vld_q  <= 1'b0;
      cmp_tag_q  <= '0;
      cmp_st_q   <= 1'b0;
      vic_push_q <= 1'b0;
      vic_blk_q  <= '0;
    end else begin
      vic_push_q <= rtn_fire && fill_rtn_dirty;
      if (rtn_fire && fill_rtn_dirty) vic_blk_q <= fill_rtn_vic_blk;
      cmp_vld_q <= drn_act;
      if (drn_act) begin
        cmp_st_q  <= tags_q[rd_idx][TAG_W];
        cmp_tag_q <= tags_q[rd_idx][TAG_W-1:0];
        drn_idx   <= drn_idx + CNT_W'(1);
        if (drn_last) drn_act <= 1'b0;
      end
      if (rtn_fire) begin
        drn_act <= 1'b1;
        drn_ent <= fill_rtn_id;
        drn_idx <= '0;
      end
    end
  end

  assign cmp_vld  = cmp_vld_q;
  assign cmp_tag  = cmp_tag_q;
  assign cmp_st   = cmp_st_q;
  assign vic_push = vic_push_q;
  assign vic_blk  = vic_blk_q;

  // R7: a stalled request keeps its entry
  a_r7_req_hold: assert property (@(posedge clk) disable iff (rst)
    (fill_req_vld && !fill_req_rdy) |=> (fill_req_vld && $stable(fill_req_id)));

  // R10: an accepted fill return targets an entry waiting for data
  a_r10_rtn_target: assert property (@(posedge clk) disable iff (rst)
    rtn_fire |-> (st_q[fill_rtn_id] == ST_PEND));

  // R9: no victim is pushed into a full queue
  a_r9_vic_room: assert property (@(posedge clk) disable iff (rst)
    vic_push |-> $past(!vic_full));

  // R8: completion beats come only from an active drain
  a_r8_cmp_src: assert property (@(posedge clk) disable iff (rst)
    cmp_vld |-> $past(drn_act));

endmodule

// File: tb/miss_merge_buf_tb.sv
module miss_merge_buf_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int TAG_W  = 8;
  localparam int BLK_W  = 26;
  localparam int ID_W   = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              p0_vld = 1'b0, p0_st = 1'b0, p1_vld = 1'b0, p1_st = 1'b0;
  logic [ADDR_W-1:0] p0_addr = '0, p1_addr = '0;
  logic [TAG_W-1:0]  p0_tag = '0, p1_tag = '0;
  logic              p0_take, p1_take;
  logic              fill_req_vld, fill_req_rdy = 1'b0;
  logic [BLK_W-1:0]  fill_req_blk;
  logic [ID_W-1:0]   fill_req_id;
  logic              fill_rtn_vld = 1'b0, fill_rtn_dirty = 1'b0;
  logic [ID_W-1:0]   fill_rtn_id = '0;
  logic [BLK_W-1:0]  fill_rtn_vic_blk = '0;
  logic              fill_rtn_rdy;
  logic              cmp_vld, cmp_st;
  logic [TAG_W-1:0]  cmp_tag;
  logic              vic_full = 1'b0, vic_push;
  logic [BLK_W-1:0]  vic_blk;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  miss_merge_buf dut_i (
    .clk(clk), .rst(rst),
    .p0_vld(p0_vld), .p0_addr(p0_addr), .p0_st(p0_st), .p0_tag(p0_tag), .p0_take(p0_take),
    .p1_vld(p1_vld), .p1_addr(p1_addr), .p1_st(p1_st), .p1_tag(p1_tag), .p1_take(p1_take),
    .fill_req_vld(fill_req_vld), .fill_req_rdy(fill_req_rdy),
    .fill_req_blk(fill_req_blk), .fill_req_id(fill_req_id),
    .fill_rtn_vld(fill_rtn_vld), .fill_rtn_id(fill_rtn_id),
    .fill_rtn_dirty(fill_rtn_dirty), .fill_rtn_vic_blk(fill_rtn_vic_blk),
    .fill_rtn_rdy(fill_rtn_rdy),
    .cmp_vld(cmp_vld), .cmp_tag(cmp_tag), .cmp_st(cmp_st),
    .vic_full(vic_full), .vic_push(vic_push), .vic_blk(vic_blk)
  );

  // Logs of request handshakes and completion beats
  logic [ID_W-1:0]  rq_id  [64];
  logic [BLK_W-1:0] rq_blk [64];
  int               rq_n = 0;
  logic [TAG_W-1:0] cb_tag [64];
  logic             cb_st  [64];
  int               cb_n = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (fill_req_vld && fill_req_rdy && rq_n < 64) begin
        rq_id[rq_n]  = fill_req_id;
        rq_blk[rq_n] = fill_req_blk;
        rq_n++;
      end
      if (cmp_vld && cb_n < 64) begin
        cb_tag[cb_n] = cmp_tag;
        cb_st[cb_n]  = cmp_st;
        cb_n++;
      end
    end
  end

  task automatic chk(input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic miss(input logic v0, input logic [31:0] a0, input logic [7:0] t0, input logic s0,
                      input logic v1, input logic [31:0] a1, input logic [7:0] t1, input logic s1,
                      input logic e0, input logic e1, input string rq);
    @(negedge clk);
    p0_vld = v0; p0_addr = a0; p0_tag = t0; p0_st = s0;
    p1_vld = v1; p1_addr = a1; p1_tag = t1; p1_st = s1;
    #1;
    if (v0) chk(rq, "p0_take", 64'(p0_take), 64'(e0));
    if (v1) chk(rq, "p1_take", 64'(p1_take), 64'(e1));
    @(posedge clk); #1;
    p0_vld = 1'b0; p1_vld = 1'b0;
  endtask

  task automatic beat(input int idx, input logic [7:0] t, input logic s, input string rq);
    chk(rq, "cmp_tag", 64'(cb_tag[idx]), 64'(t));
    chk(rq, "cmp_st",  64'(cb_st[idx]),  64'(s));
  endtask

  task automatic ret_clean(input logic [ID_W-1:0] id);
    @(negedge clk);
    fill_rtn_vld = 1'b1; fill_rtn_id = id; fill_rtn_dirty = 1'b0;
    #1;
    chk("R9", "clean rtn rdy", 64'(fill_rtn_rdy), 64'd1);
    @(posedge clk); #1;
    fill_rtn_vld = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  typedef struct packed {
    logic v0; logic [31:0] a0; logic [7:0] t0; logic s0;
    logic v1; logic [31:0] a1; logic [7:0] t1; logic s1;
    logic e0; logic e1;
  } row_t;

  // Merge patterns, fill requests held off
  localparam row_t ROWS [4] = '{
    '{1'b1, 32'h400, 8'd1, 1'b0, 1'b0, 32'h0,   8'd0, 1'b0, 1'b1, 1'b0}, // R2 new block
    '{1'b1, 32'h43F, 8'd2, 1'b1, 1'b0, 32'h0,   8'd0, 1'b0, 1'b1, 1'b0}, // R3 low bits ignored
    '{1'b1, 32'h800, 8'd3, 1'b0, 1'b1, 32'h81C, 8'd4, 1'b1, 1'b1, 1'b1}, // R4 same new block
    '{1'b1, 32'h404, 8'd5, 1'b0, 1'b1, 32'hC00, 8'd6, 1'b0, 1'b1, 1'b1}  // merge plus alloc
  };

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int base;
    logic [ID_W-1:0] eid;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1", "fill_req_vld", 64'(fill_req_vld), 64'd0);
    chk("R1", "cmp_vld", 64'(cmp_vld), 64'd0);
    chk("R1", "vic_push", 64'(vic_push), 64'd0);
    chk("R1", "fill_rtn_rdy", 64'(fill_rtn_rdy), 64'd1);
    p0_vld = 1'b1; p1_vld = 1'b1; p0_addr = 32'h4000; p1_addr = 32'h8000;
    #1;
    chk("R1", "p0_take", 64'(p0_take), 64'd1);
    chk("R1", "p1_take", 64'(p1_take), 64'd1);
    p0_vld = 1'b0; p1_vld = 1'b0;

    for (int i = 0; i < 4; i++) begin
      miss(ROWS[i].v0, ROWS[i].a0, ROWS[i].t0, ROWS[i].s0,
           ROWS[i].v1, ROWS[i].a1, ROWS[i].t1, ROWS[i].s1,
           ROWS[i].e0, ROWS[i].e1, "R2/R3/R4 table");
    end

    // R2: head request is entry 0 for block 0x10, held while not ready
    @(negedge clk);
    chk("R2", "fill_req_vld", 64'(fill_req_vld), 64'd1);
    chk("R2", "fill_req_id", 64'(fill_req_id), 64'd0);
    chk("R2", "fill_req_blk", 64'(fill_req_blk), 64'h10);
    fill_req_rdy = 1'b1;
    repeat (5) @(negedge clk);
    // R3/R4/R7: exactly three requests in allocation order
    chk("R3", "request count", 64'(rq_n), 64'd3);
    chk("R7", "req0 id", 64'(rq_id[0]), 64'd0);
    chk("R7", "req1 id", 64'(rq_id[1]), 64'd1);
    chk("R7", "req2 id", 64'(rq_id[2]), 64'd2);
    chk("R4", "req1 blk", 64'(rq_blk[1]), 64'h20);
    chk("R7", "req2 blk", 64'(rq_blk[2]), 64'h30);
    chk("R7", "queue empty", 64'(fill_req_vld), 64'd0);

    // R10/R9: return entry 0, then offer dirty return of entry 1
    @(negedge clk);
    fill_rtn_vld = 1'b1; fill_rtn_id = 4'd0; fill_rtn_dirty = 1'b0;
    #1;
    chk("R1", "rtn rdy idle", 64'(fill_rtn_rdy), 64'd1);
    @(posedge clk); #1;
    fill_rtn_id = 4'd1; fill_rtn_dirty = 1'b1; fill_rtn_vic_blk = 26'h55;
    vic_full = 1'b1;
    @(negedge clk);
    chk("R10", "rdy during drain", 64'(fill_rtn_rdy), 64'd0);
    vic_full = 1'b0;
    #1;
    chk("R10", "rdy during drain, room", 64'(fill_rtn_rdy), 64'd0);
    vic_full = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9", "dirty rdy with full queue", 64'(fill_rtn_rdy), 64'd0);
    chk("R9", "no push while full", 64'(vic_push), 64'd0);
    vic_full = 1'b0;
    #1;
    chk("R9", "dirty rdy with room", 64'(fill_rtn_rdy), 64'd1);
    @(posedge clk); #1;
    fill_rtn_vld = 1'b0; fill_rtn_dirty = 1'b0;
    @(negedge clk);
    chk("R9", "vic_push", 64'(vic_push), 64'd1);
    chk("R9", "vic_blk", 64'(vic_blk), 64'h55);
    @(negedge clk);
    chk("R9", "vic_push pulse", 64'(vic_push), 64'd0);
    repeat (6) @(negedge clk);
    // R8: beats of entry 0 then entry 1
    chk("R8", "beat count", 64'(cb_n), 64'd5);
    beat(0, 8'd1, 1'b0, "R8");
    beat(1, 8'd2, 1'b1, "R8");
    beat(2, 8'd5, 1'b0, "R8");
    beat(3, 8'd3, 1'b0, "R8 port order");
    beat(4, 8'd4, 1'b1, "R8 port order");

    // R9: clean return ignores a full victim queue
    vic_full = 1'b1;
    ret_clean(4'd2);
    vic_full = 1'b0;
    chk("R9", "beat count clean", 64'(cb_n), 64'd6);
    beat(5, 8'd6, 1'b0, "R9");

    // R8: freed entry reallocated for its old block
    base = rq_n;
    miss(1'b1, 32'h410, 8'd7, 1'b1, 1'b0, 32'h0, 8'd0, 1'b0, 1'b1, 1'b0, "R8");
    repeat (2) @(negedge clk);
    chk("R8", "realloc request", 64'(rq_n), 64'(base + 1));
    chk("R8", "realloc id", 64'(rq_id[base]), 64'd0);
    chk("R8", "realloc blk", 64'(rq_blk[base]), 64'h10);
    ret_clean(4'd0);
    beat(6, 8'd7, 1'b1, "R8");

    // R6: eight references fill one entry, the ninth is refused
    base = rq_n;
    for (int k = 0; k < 4; k++) begin
      miss(1'b1, 32'h1000 + 32'(k), 8'(8 + 2*k), 1'b0,
           1'b1, 32'h1020 + 32'(k), 8'(9 + 2*k), 1'b1, 1'b1, 1'b1, "R6 fill");
    end
    miss(1'b1, 32'h1004, 8'd40, 1'b0, 1'b1, 32'h1008, 8'd41, 1'b0, 1'b0, 1'b0, "R6 overflow");
    repeat (2) @(negedge clk);
    chk("R6", "one request", 64'(rq_n), 64'(base + 1));
    eid = rq_id[base];
    base = cb_n;
    ret_clean(eid);
    chk("R6", "eight beats", 64'(cb_n), 64'(base + 8));
    for (int k = 0; k < 8; k++) beat(base + k, 8'(8 + k), 1'(k % 2), "R6");

    // R5: sixteen blocks use every entry
    fill_req_rdy = 1'b0;
    for (int k = 0; k < 8; k++) begin
      miss(1'b1, 32'h10000 + 32'(128*k), 8'(50 + k), 1'b0,
           1'b1, 32'h10040 + 32'(128*k), 8'(60 + k), 1'b0, 1'b1, 1'b1, "R5 fill");
    end
    miss(1'b1, 32'h20000, 8'd70, 1'b0, 1'b1, 32'h10004, 8'd71, 1'b0, 1'b0, 1'b1, "R5 full");
    @(negedge clk);
    chk("R7", "head oldest", 64'(fill_req_blk), 64'h400);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule